// File: doc/BRIEF.md
# Dual-Channel Power Mode Sequencer

This block decides, cycle by cycle, which of the two converter channels is powered and when each channel's output data may be trusted. It samples an active-low full power-down control and a two-bit sleep bus, resynchronizes both into the sample clock domain, and runs one small state machine per channel. Each machine moves through powered-off, sleeping, waking and running states. While a channel wakes, a cycle counter holds its data-valid low for the startup wait that applies.

Two startup waits exist. A channel coming out of sleep needs a short wait. A channel waking for the first time after a full power down needs a much longer wait, because the references must settle first. The power-down input overrides the sleep bus completely. Until the power-down input has been seen low once after reset, the block keeps both channels off whatever the sleep bus says. The block also gives a clock-enable for the internal sample clocking, and a flag that tells the output stage to hold its data at zero.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `ch_active`, `ch_valid` and `clk_en` are all zero and `out_clr` is one.
- R2: Before `pd_n_in` has been sampled low for the first time after reset, no channel becomes active or valid, for any value of `slp_in`.
- R3: A low on `pd_n_in` applied before rising edge 1 clears `ch_active`, `ch_valid` and `clk_en` and sets `out_clr` from edge SYNC_STAGES+1 onward. While `pd_n_in` stays low, `slp_in` has no effect.
- R4: Bit 0 of `slp_in` requests channel 0 and bit 1 requests channel 1. A bit value of 1 means active, so 00 puts both channels to sleep, 01 wakes only channel 0, 10 wakes only channel 1 and 11 wakes both.
- R5: A wake request from sleep, applied before edge 1, raises the channel's `ch_active` at edge SYNC_STAGES+1 and its `ch_valid` at edge SYNC_STAGES+1+SLP_WAKE_CYC (default 20). A sleep request lowers both at edge SYNC_STAGES+1.
- R6: The first wake of a channel after a power-down release waits PD_WAKE_CYC cycles (default 900) instead of SLP_WAKE_CYC.
- R7: If a waking channel is sent back to sleep or power down, its count is dropped and its `ch_active` falls. The next wake restarts the full count. The long wait stays in force until the channel has once reached the valid state.
- R8: `clk_en` is high exactly when at least one channel is active. `out_clr` is high only during power down and before the first power down, and it stays low while both channels merely sleep.
- R9: A sleep or wake request on one channel leaves the other channel's `ch_active` and `ch_valid` unchanged.
- R10: `ch_valid` of a channel is never high while its `ch_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pd_n_in | input | 1 | Full power-down request, active low, asynchronous |
| slp_in | input | NUM_CH | Per-channel run request, 1 = active, asynchronous |
| ch_active | output | NUM_CH | Channel powered (waking or running) |
| ch_valid | output | NUM_CH | Channel startup wait complete, data usable |
| clk_en | output | 1 | Enable for internal sample clocking |
| out_clr | output | 1 | Hold digital outputs at zero (power down) |

## Verification
A wrong channel state or a miscounted wait shows up at `ch_valid` as an edge that is one or more cycles early or late. The bench checks for it on the exact edge that R5 and R6 give. Each channel has only one counter, so a corrupt count or a stuck long-wait flag shows as a wrong wake interval on the next wake, that is, within at most PD_WAKE_CYC+3 cycles. A lost power-down arm is different: it holds both channels off forever, and the bench sees it on the first wake after the first power down. A free-running comparison against a cycle model of the requirements catches any divergence of the four outputs in the cycle where it happens.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_SLEEP = 2'd1,
        CH_WAKE  = 2'd2,
        CH_RUN   = 2'd3
    } ch_state_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= rst_val;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan
    import pwr_seq_pkg::*;
#(
    parameter int PD_WAKE_CYC  = 900,
    parameter int SLP_WAKE_CYC = 20,
    parameter int CNT_W        = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic run_req,
    output logic active,
    output logic valid,
    output logic off
);
    localparam logic [CNT_W-1:0] PD_LAST  = CNT_W'(PD_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] SLP_LAST = CNT_W'(SLP_WAKE_CYC - 1);

    typedef struct packed {
        ch_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             cold;
    } chan_t;

    chan_t cur_q, cur_d;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        cur_d    = cur_q;
        last_cnt = cur_q.cold ? PD_LAST : SLP_LAST;
        if (!pwr_ok) begin
            cur_d.st   = CH_OFF;
            cur_d.cnt  = '0;
            cur_d.cold = 1'b1;
        end else begin
            unique case (cur_q.st)
                CH_OFF: begin
                    cur_d.cnt = '0;
                    cur_d.st  = run_req ? CH_WAKE : CH_SLEEP;
                end
                CH_SLEEP: begin
                    cur_d.cnt = '0;
                    if (run_req) cur_d.st = CH_WAKE;
                end
                CH_WAKE: begin
                    if (!run_req) begin
                        cur_d.st  = CH_SLEEP;
                        cur_d.cnt = '0;
                    end else if (cur_q.cnt == last_cnt) begin
                        cur_d.st   = CH_RUN;
                        cur_d.cnt  = '0;
                        cur_d.cold = 1'b0;
                    end else begin
                        cur_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                CH_RUN: begin
                    if (!run_req) cur_d.st = CH_SLEEP;
                end
                default: cur_d.st = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= CH_OFF;
            cur_q.cnt  <= '0;
            cur_q.cold <= 1'b1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign active = (cur_q.st == CH_WAKE) || (cur_q.st == CH_RUN);
    assign valid  = (cur_q.st == CH_RUN);
    assign off    = (cur_q.st == CH_OFF);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
    parameter int NUM_CH       = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PD_WAKE_CYC  = 900,
    parameter int SLP_WAKE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n_in,
    input  logic [NUM_CH-1:0] slp_in,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] ch_valid,
    output logic              clk_en,
    output logic              out_clr
);
    localparam int MAX_WAKE = (PD_WAKE_CYC > SLP_WAKE_CYC) ? PD_WAKE_CYC : SLP_WAKE_CYC;
    localparam int CNT_W    = $clog2(MAX_WAKE + 1);
    localparam int SW       = NUM_CH + 1;

    logic [SW-1:0]     ctl_s;
    logic              pd_n_s;
    logic [NUM_CH-1:0] req_s;
    logic [NUM_CH-1:0] ch_off;

    typedef struct packed {
        logic armed;
    } top_t;
    top_t top_q, top_d;

    pwr_seq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val ({1'b1, {NUM_CH{1'b0}}}),
        .din     ({pd_n_in, slp_in}),
        .dout    (ctl_s)
    );

    assign pd_n_s = ctl_s[SW-1];
    assign req_s  = ctl_s[NUM_CH-1:0];

    always_comb begin
        top_d       = top_q;
        top_d.armed = top_q.armed | ~pd_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q.armed <= 1'b0;
        else        top_q       <= top_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwr_seq_chan #(
            .PD_WAKE_CYC (PD_WAKE_CYC),
            .SLP_WAKE_CYC(SLP_WAKE_CYC),
            .CNT_W       (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_ok (pd_n_s & top_q.armed),
            .run_req(req_s[c]),
            .active (ch_active[c]),
            .valid  (ch_valid[c]),
            .off    (ch_off[c])
        );
    end

    assign clk_en  = |ch_active;
    assign out_clr = &ch_off;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int NUM_CH       = 2,
    parameter int SLP_WAKE_CYC = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_n_in,
    input logic [NUM_CH-1:0] ch_active,
    input logic [NUM_CH-1:0] ch_valid,
    input logic              clk_en,
    input logic              out_clr
);
    logic saw_pd_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        saw_pd_q <= 1'b0;
        else if (!pd_n_in) saw_pd_q <= 1'b1;
    end

    p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !saw_pd_q |-> (ch_active == '0 && ch_valid == '0));

    p_clear_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_clr |-> (ch_active == '0 && !clk_en));

    p_clk_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid != '0) |-> clk_en);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        int wake_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             wake_q <= 0;
            else if (!ch_active[c]) wake_q <= 0;
            else if (!ch_valid[c] && wake_q < SLP_WAKE_CYC + 1) wake_q <= wake_q + 1;
        end

        p_valid_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[c] |-> ch_active[c]);

        p_rise_from_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_valid[c]) |-> $past(ch_active[c]));

        p_wake_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_valid[c]) |-> (wake_q >= SLP_WAKE_CYC));
    end
endmodule

bind pwr_seq_top pwr_seq_chk #(.NUM_CH(NUM_CH), .SLP_WAKE_CYC(SLP_WAKE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_n_in  (pd_n_in),
    .ch_active(ch_active),
    .ch_valid (ch_valid),
    .clk_en   (clk_en),
    .out_clr  (out_clr)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;
    localparam int SY = 2;
    localparam int SW = 20;
    localparam int PW = 900;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n_in = 1'b1;
    logic [1:0] slp_in = 2'b11;
    logic [1:0] ch_active, ch_valid;
    logic       clk_en, out_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_top #(.NUM_CH(2), .SYNC_STAGES(SY), .PD_WAKE_CYC(PW), .SLP_WAKE_CYC(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_n_in(pd_n_in), .slp_in(slp_in),
        .ch_active(ch_active), .ch_valid(ch_valid), .clk_en(clk_en), .out_clr(out_clr)
    );

    // cycle model built from the requirements
    logic [2:0] m1 = 3'b100, m2 = 3'b100;
    bit   m_armed = 0, m_off = 1;
    bit   m_on[2], m_cold[2];
    int   m_left[2];

    function automatic logic [5:0] model_out();
        logic [1:0] a, v;
        for (int c = 0; c < 2; c++) begin
            a[c] = m_on[c];
            v[c] = m_on[c] && (m_left[c] == 0);
        end
        return {a, v, (a != 2'b00), m_off};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = 3'b100; m2 = 3'b100; m_armed = 0; m_off = 1;
            for (int c = 0; c < 2; c++) begin m_on[c] = 0; m_left[c] = 0; m_cold[c] = 1; end
        end else begin
            bit ok;
            ok = m2[2] && m_armed;
            m_armed = m_armed | !m2[2];
            m_off = !ok;
            for (int c = 0; c < 2; c++) begin
                if (!ok) begin m_on[c] = 0; m_left[c] = 0; m_cold[c] = 1; end
                else if (!m2[c]) begin m_on[c] = 0; m_left[c] = 0; end
                else if (!m_on[c]) begin m_on[c] = 1; m_left[c] = m_cold[c] ? PW : SW; end
                else if (m_left[c] > 0) begin
                    if (m_left[c] == 1) m_cold[c] = 0;
                    m_left[c] = m_left[c] - 1;
                end
            end
            m2 = m1;
            m1 = {pd_n_in, slp_in};
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n)
            chk("R8/R5 model", {2'b00, ch_active, ch_valid, clk_en, out_clr}, {2'b00, model_out()});
    end

    task automatic drive(input logic pd, input logic [1:0] s);
        @(negedge clk);
        pd_n_in = pd;
        slp_in  = s;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        step(3);
        chk("R1 reset", {ch_active, ch_valid, clk_en, out_clr}, 6'b0000_01);
        @(negedge clk); rst_n = 1'b1;
        step(1);
        chk("R1 after release", {ch_active, ch_valid, clk_en, out_clr}, 6'b0000_01);

        // R2: not yet armed
        step(60);
        chk("R2 unarmed 11", {ch_active, ch_valid}, 4'b0000);
        drive(1, 2'b01); step(30);
        chk("R2 unarmed 01", {ch_active, ch_valid}, 4'b0000);
        drive(1, 2'b10); step(30);
        chk("R2 unarmed 10", {ch_active, ch_valid, out_clr}, 5'b0000_1);

        // R6: first wake after power down
        drive(0, 2'b11); step(6);
        chk("R3 pd held", {ch_active, clk_en, out_clr}, 4'b00_01);
        drive(1, 2'b11); step(SY);
        chk("R6 active not yet", {ch_active}, 2'b00);
        step(1);
        chk("R6 active edge", {ch_active, ch_valid, clk_en, out_clr}, 6'b1100_10);
        step(PW - 1);
        chk("R6 valid not yet", {ch_valid}, 2'b00);
        step(1);
        chk("R6 valid edge", {ch_valid}, 2'b11);

        // R9/R4/R5: sleep channel 1 only, then rewake short
        drive(1, 2'b01); step(SY);
        chk("R5 sleep not yet", {ch_active}, 2'b11);
        step(1);
        chk("R9 ch0 kept, R4 bit1", {ch_active, ch_valid}, 4'b01_01);
        drive(1, 2'b11); step(SY + SW);
        chk("R5 short not yet", {ch_valid}, 2'b01);
        step(1);
        chk("R5 short wake", {ch_valid}, 2'b11);

        // R4/R8: both asleep, then only ch1
        drive(1, 2'b00); step(SY + 1);
        chk("R8 sleep no clear", {ch_active, clk_en, out_clr}, 4'b00_00);
        drive(1, 2'b10); step(SY + 1);
        chk("R4 ch1 only active", {ch_active, ch_valid}, 4'b10_00);
        step(SW - 1);
        chk("R5 ch1 not yet", {ch_valid}, 2'b00);
        step(1);
        chk("R4 ch1 only valid", {ch_valid}, 2'b10);

        // R7: abort during short count
        drive(1, 2'b01); step(SY + 1 + 10);
        drive(1, 2'b00); step(SY + 1);
        chk("R7 abort drops active", {ch_active, ch_valid}, 4'b0000);
        drive(1, 2'b01); step(SY + SW);
        chk("R7 restart not early", {ch_valid}, 2'b00);
        step(1);
        chk("R7 restart full", {ch_valid}, 2'b01);

        // R3: power down overrides sleep bus
        drive(0, 2'b11); step(SY);
        chk("R3 not yet", {ch_active}, 2'b01);
        step(1);
        chk("R3 cleared", {ch_active, ch_valid, clk_en, out_clr}, 6'b0000_01);
        for (int i = 0; i < 4; i++) begin
            drive(0, 2'(i)); step(5);
            chk("R3 bus ignored", {ch_active, ch_valid, out_clr}, 5'b0000_1);
        end

        // R7: abort during long count keeps long wait
        drive(1, 2'b11); step(100);
        drive(1, 2'b00); step(SY + 1);
        chk("R7 cold abort", {ch_active}, 2'b00);
        drive(1, 2'b11); step(SY + SW + 5);
        chk("R7 still cold", {ch_valid}, 2'b00);
        step(PW - SW - 5);
        chk("R7 cold not yet", {ch_valid}, 2'b00);
        step(1);
        chk("R7 cold full", {ch_valid}, 2'b11);

        // random phase against the model
        cmp_en = 1'b1;
        for (int seg = 0; seg < 400; seg++) begin
            if ($urandom_range(11) == 0) drive(0, 2'($urandom_range(3)));
            else                         drive(1, 2'($urandom_range(3)));
            step($urandom_range(40, 1));
        end
        cmp_en = 1'b0;
        done = 1'b1;
        summary();
    end
endmodule